// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel. It moves elements between a fixed device address and a memory address that steps forward. Software chooses one of two run modes. In single mode the channel works from the four words presented on its register inputs. In chain mode it fetches four-word descriptors through its memory port, starting at the pointer on the next-pointer input, and keeps following the links until a descriptor marks itself as the last one.

Descriptor fetches and element moves share one request/response memory port. Each element takes one read and then one write. The source and the destination are set by a direction input. The channel reports a 2-bit activity code. It pulses `done_o` when a finished descriptor asks for an interrupt, and it pulses `err_o` when it has to give up on a transfer. Arbitration between channels and the peripheral request handshake are handled outside this block.

Top module: `dmach_engine`

## Requirements
- R1: In chain mode (`mode_i` = 1) the channel clears the two low bits of the pointer to form a base address. It then reads four words at base+0x0, +0x4, +0x8 and +0xC. These words are the device address, the memory address, the size word and the next word.
- R2: Size word bits [13:12] set the element width: 3 gives 1 byte, 2 gives 2 bytes and 0 gives 4 bytes. Bits [10:0] hold the element count. A count of zero moves no data but still completes the descriptor.
- R3: A count above 0x3FF with a 1-byte or 2-byte width is illegal. Any count up to 0x7FF is legal with a 4-byte width. An illegal count raises the error pulse and moves no data.
- R4: In the next word, bit 0 requests an interrupt and bit 1 requests a continuation. In chain mode a continuation fetches the next descriptor from bits [31:2] with the low two bits cleared. Without a continuation the channel goes back to idle.
- R5: In single mode (`mode_i` = 2) the channel runs the descriptor given on `dev_addr_i`, `mem_addr_i`, `size_i` and `next_i`, as captured at start. It never fetches a descriptor and never follows a continuation.
- R6: `state_o` reads 0 when idle, 1 during a descriptor read, 2 during the one-cycle descriptor check and 3 while elements move. It returns to 0 after the final descriptor.
- R7: A start takes effect only while the channel is idle. A start pulse given while the channel is busy changes nothing.
- R8: When `dir_i` = 1, each element is read from memory and written to the device; when `dir_i` = 0 the direction is reversed. The memory address advances by the element width after every element, and the device address stays fixed. `mem_size_o` gives log2 of the access size in bytes.
- R9: `done_o` pulses for one cycle at the end of each descriptor whose interrupt bit is set.
- R10: A width code of 1, or a response that carries `mem_err_i`, raises `err_o` for one cycle and returns the channel to idle. No further accesses follow.
- R11: Setting `mode_i` to 0 while the channel is busy aborts the transfer. The channel is idle on the next cycle and issues no done pulse.
- R12: A request holds `mem_req_o`, `mem_addr_o` and `mem_we_o` steady until `mem_ack_i` arrives. The write data is the value returned by the element's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 disabled/abort, 1 chain, 2 single |
| dir_i | input | 1 | 1 memory to device, 0 device to memory |
| start_i | input | 1 | Start pulse, honoured only when idle |
| dev_addr_i | input | AW | Device address for single mode |
| mem_addr_i | input | AW | Memory address for single mode |
| size_i | input | DW | Size word for single mode |
| next_i | input | AW | Next word (single) or first descriptor pointer (chain) |
| state_o | output | 2 | Activity code |
| done_o | output | 1 | Descriptor-complete interrupt pulse |
| err_o | output | 1 | Error pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Request byte address |
| mem_size_o | output | 2 | log2 of access bytes |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Response for the current request |
| mem_err_i | input | 1 | Response carries a bus error |
| mem_rdata_i | input | DW | Read data |

## Verification
The bench sweeps every legal width code, both directions and several counts in single mode, and compares each logged write address and data value against arithmetic. A wrong address step or a swapped direction shows up as a misplaced write. A three-descriptor chain checks that links are followed and that interrupts come only from the descriptors that request them; a design that ignored bit 1 would stop early, and one that ignored bit 0 would miscount done pulses. The edge cases are the largest legal and the first illegal count, width code 1, bus errors during both a fetch and a data read, a zero count, an abort part way through, and a start pulse while busy. A design that mishandled any of these would keep writing, hang, or overwrite the transfer in flight.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   localparam logic [1:0] MODE_OFF    = 2'd0;
   localparam logic [1:0] MODE_CHAIN  = 2'd1;
   localparam logic [1:0] MODE_SINGLE = 2'd2;

   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_DESC = 2'd1,
      ACT_WAIT = 2'd2,
      ACT_XFER = 2'd3
   } act_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_CHECK,
      S_READ,
      S_WRITE
   } seq_e;

endpackage

// File: rtl/dmach_width_dec.sv
module dmach_width_dec #(
   parameter int CNT_W = 11
) (
   input  logic [1:0]       code_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             legal_o,
   output logic [1:0]       lg_o
);
   localparam logic [CNT_W-1:0] NARROW_MAX = CNT_W'((1 << (CNT_W - 1)) - 1);

   initial begin
      assert (CNT_W >= 2) else $error("dmach_width_dec: CNT_W must be at least 2");
   end

   always_comb begin
      legal_o = 1'b0;
      lg_o    = 2'd2;
      case (code_i)
         2'd3: begin lg_o = 2'd0; legal_o = (count_i <= NARROW_MAX); end
         2'd2: begin lg_o = 2'd1; legal_o = (count_i <= NARROW_MAX); end
         2'd0: begin lg_o = 2'd2; legal_o = 1'b1; end
         default: begin lg_o = 2'd2; legal_o = 1'b0; end
      endcase
   end
endmodule

// File: rtl/dmach_desc_regs.sv
module dmach_desc_regs #(
   parameter int DW = 32,
   parameter int NW = 4,
   localparam int IW = $clog2(NW)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_all_i,
   input  logic [NW-1:0][DW-1:0]  all_i,
   input  logic                   cap_en_i,
   input  logic [IW-1:0]          cap_idx_i,
   input  logic [DW-1:0]          cap_data_i,
   output logic [NW-1:0][DW-1:0]  words_o
);
   initial begin
      assert (NW >= 2) else $error("dmach_desc_regs: NW must be at least 2");
   end

   for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words_o[g] <= '0;
         else if (load_all_i)
            words_o[g] <= all_i[g];
         else if (cap_en_i && cap_idx_i == IW'(g))
            words_o[g] <= cap_data_i;
      end
   end
endmodule

// File: rtl/dmach_stepper.sv
module dmach_stepper #(
   parameter int AW    = 32,
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [1:0]       lg_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [AW-1:0]    mem_i,
   input  logic [AW-1:0]    dev_i,
   output logic [AW-1:0]    mem_ptr_o,
   output logic [AW-1:0]    dev_ptr_o,
   output logic             last_o
);
   logic [CNT_W-1:0] left_q;
   logic [1:0]       lg_q;
   logic [AW-1:0]    inc;

   initial begin
      assert (AW >= 8) else $error("dmach_stepper: AW must be at least 8");
   end

   assign inc    = AW'(1) << lg_q;
   assign last_o = (left_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q    <= '0;
         lg_q      <= 2'd0;
         mem_ptr_o <= '0;
         dev_ptr_o <= '0;
      end else if (load_i) begin
         left_q    <= cnt_i;
         lg_q      <= lg_i;
         mem_ptr_o <= mem_i;
         dev_ptr_o <= dev_i;
      end else if (step_i) begin
         left_q    <= left_q - CNT_W'(1);
         mem_ptr_o <= mem_ptr_o + inc;
      end
   end

   // R8: never step past the element count
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> left_q != '0);
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
   import dmach_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int CNT_W    = 11,
   parameter int WSEL_LSB = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic          dir_i,
   input  logic          start_i,
   input  logic [AW-1:0] dev_addr_i,
   input  logic [AW-1:0] mem_addr_i,
   input  logic [DW-1:0] size_i,
   input  logic [AW-1:0] next_i,
   output logic [1:0]    state_o,
   output logic          done_o,
   output logic          err_o,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [1:0]    mem_size_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic          mem_ack_i,
   input  logic          mem_err_i,
   input  logic [DW-1:0] mem_rdata_i
);
   localparam int NW = 4;
   localparam int IW = $clog2(NW);

   initial begin
      assert (AW <= DW) else $error("dmach_engine: AW must not exceed DW");
      assert (WSEL_LSB > CNT_W) else $error("dmach_engine: width field overlaps count");
      assert (WSEL_LSB + 2 < DW) else $error("dmach_engine: width field outside size word");
   end

   seq_e                seq_q;
   logic [IW-1:0]       widx_q;
   logic [AW-1:0]       base_q;
   logic [DW-1:0]       data_q;
   logic                dir_q, single_q, done_q, err_q;
   logic [NW-1:0][DW-1:0] words, all_in;
   logic [DW-1:0]       w_size, w_next;
   logic [AW-1:0]       w_dev, w_mem, nxt_base, mem_ptr, dev_ptr;
   logic [CNT_W-1:0]    cnt;
   logic                legal, last, follow, running;
   logic [1:0]          lg;
   logic                desc_load, cap_en, step_load, step;
   logic                unused_bits;

   assign w_dev    = words[0][AW-1:0];
   assign w_mem    = words[1][AW-1:0];
   assign w_size   = words[2];
   assign w_next   = words[3];
   assign cnt      = w_size[CNT_W-1:0];
   assign nxt_base = {w_next[AW-1:2], 2'b00};
   assign follow   = !single_q && w_next[1];
   assign running  = (mode_i != MODE_OFF);
   assign unused_bits = ^{w_size[DW-1:WSEL_LSB+2], w_size[WSEL_LSB-1:CNT_W], next_i[1:0]};

   assign all_in    = {DW'(next_i), size_i, DW'(mem_addr_i), DW'(dev_addr_i)};
   assign desc_load = (seq_q == S_IDLE) && start_i && (mode_i == MODE_SINGLE);
   assign cap_en    = (seq_q == S_FETCH) && mem_ack_i && !mem_err_i && running;
   assign step_load = (seq_q == S_CHECK) && legal && running;
   assign step      = (seq_q == S_WRITE) && mem_ack_i && !mem_err_i && running;

   dmach_desc_regs #(.DW(DW), .NW(NW)) u_desc (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_all_i (desc_load),
      .all_i      (all_in),
      .cap_en_i   (cap_en),
      .cap_idx_i  (widx_q),
      .cap_data_i (mem_rdata_i),
      .words_o    (words)
   );

   dmach_width_dec #(.CNT_W(CNT_W)) u_wdec (
      .code_i  (w_size[WSEL_LSB +: 2]),
      .count_i (cnt),
      .legal_o (legal),
      .lg_o    (lg)
   );

   dmach_stepper #(.AW(AW), .CNT_W(CNT_W)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (step_load),
      .step_i    (step),
      .lg_i      (lg),
      .cnt_i     (cnt),
      .mem_i     (w_mem),
      .dev_i     (w_dev),
      .mem_ptr_o (mem_ptr),
      .dev_ptr_o (dev_ptr),
      .last_o    (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= S_IDLE;
         widx_q   <= '0;
         base_q   <= '0;
         data_q   <= '0;
         dir_q    <= 1'b0;
         single_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (seq_q != S_IDLE && !running) begin
            seq_q <= S_IDLE;
         end else begin
            case (seq_q)
               S_IDLE: begin
                  if (start_i && mode_i == MODE_CHAIN) begin
                     base_q   <= {next_i[AW-1:2], 2'b00};
                     widx_q   <= '0;
                     dir_q    <= dir_i;
                     single_q <= 1'b0;
                     seq_q    <= S_FETCH;
                  end else if (start_i && mode_i == MODE_SINGLE) begin
                     dir_q    <= dir_i;
                     single_q <= 1'b1;
                     seq_q    <= S_CHECK;
                  end
               end
               S_FETCH: begin
                  if (mem_ack_i) begin
                     if (mem_err_i) begin
                        err_q <= 1'b1;
                        seq_q <= S_IDLE;
                     end else if (widx_q == IW'(NW - 1)) begin
                        seq_q <= S_CHECK;
                     end else begin
                        widx_q <= widx_q + IW'(1);
                     end
                  end
               end
               S_CHECK: begin
                  if (!legal) begin
                     err_q <= 1'b1;
                     seq_q <= S_IDLE;
                  end else if (cnt == '0) begin
                     done_q <= w_next[0];
                     if (follow) begin
                        base_q <= nxt_base;
                        widx_q <= '0;
                        seq_q  <= S_FETCH;
                     end else begin
                        seq_q <= S_IDLE;
                     end
                  end else begin
                     seq_q <= S_READ;
                  end
               end
               S_READ: begin
                  if (mem_ack_i) begin
                     if (mem_err_i) begin
                        err_q <= 1'b1;
                        seq_q <= S_IDLE;
                     end else begin
                        data_q <= mem_rdata_i;
                        seq_q  <= S_WRITE;
                     end
                  end
               end
               S_WRITE: begin
                  if (mem_ack_i) begin
                     if (mem_err_i) begin
                        err_q <= 1'b1;
                        seq_q <= S_IDLE;
                     end else if (last) begin
                        done_q <= w_next[0];
                        if (follow) begin
                           base_q <= nxt_base;
                           widx_q <= '0;
                           seq_q  <= S_FETCH;
                        end else begin
                           seq_q <= S_IDLE;
                        end
                     end else begin
                        seq_q <= S_READ;
                     end
                  end
               end
               default: seq_q <= S_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      mem_req_o  = 1'b0;
      mem_we_o   = 1'b0;
      mem_addr_o = '0;
      mem_size_o = 2'd2;
      state_o    = ACT_IDLE;
      case (seq_q)
         S_FETCH: begin
            state_o    = ACT_DESC;
            mem_req_o  = 1'b1;
            mem_addr_o = base_q + {{(AW-IW-2){1'b0}}, widx_q, 2'b00};
         end
         S_CHECK: state_o = ACT_WAIT;
         S_READ: begin
            state_o    = ACT_XFER;
            mem_req_o  = 1'b1;
            mem_addr_o = dir_q ? mem_ptr : dev_ptr;
            mem_size_o = lg;
         end
         S_WRITE: begin
            state_o    = ACT_XFER;
            mem_req_o  = 1'b1;
            mem_we_o   = 1'b1;
            mem_addr_o = dir_q ? dev_ptr : mem_ptr;
            mem_size_o = lg;
         end
         default: state_o = ACT_IDLE;
      endcase
   end

   assign mem_wdata_o = data_q;
   assign done_o      = done_q;
   assign err_o       = err_q;

   // R6: no memory traffic while idle or checking
   p_quiet_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ACT_IDLE || state_o == ACT_WAIT) |-> !mem_req_o);

   // R12: a pending request is held steady until it is acknowledged
   p_hold_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i && running) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R1: descriptor reads are word aligned reads
   p_fetch_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ACT_DESC) |-> (mem_addr_o[1:0] == 2'b00 && !mem_we_o));

   // R11: disabling the channel forces idle on the next cycle
   p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_OFF) |=> (state_o == ACT_IDLE));

   // R9: done follows a check or a final access
   p_done_from_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(state_o) == ACT_XFER || $past(state_o) == ACT_WAIT));

   // R10: error and done never coincide, and error only follows busy
   p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!done_o && $past(state_o) != ACT_IDLE));
endmodule

// File: tb/sim_dmach_engine.sv
module sim_dmach_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        dir = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dev_a = '0, mem_a = '0, size_w = '0, next_w = '0;
   logic [1:0]  state;
   logic        done, errp, req, we;
   logic [31:0] addr, wdata;
   logic [1:0]  msz;
   logic        ack, berr;
   logic [31:0] rdata;

   logic [31:0] dmem [0:63];
   logic [31:0] err_addr = '0;
   logic        err_arm = 1'b0;
   logic [31:0] wl_addr [0:63];
   logic [31:0] wl_data [0:63];
   logic [1:0]  wl_sz   [0:63];
   int          wcount, done_cnt, err_cnt;
   int unsigned n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   dmach_engine u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir), .start_i(start),
      .dev_addr_i(dev_a), .mem_addr_i(mem_a), .size_i(size_w), .next_i(next_w),
      .state_o(state), .done_o(done), .err_o(errp),
      .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(msz),
      .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_err_i(berr), .mem_rdata_i(rdata)
   );

   function automatic logic [31:0] rd_word(input logic [31:0] a);
      if (a[31:8] == 24'h4) return dmem[a[7:2]];
      return a ^ 32'hC300_0000;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0; berr <= 1'b0; rdata <= '0;
         wcount <= 0; done_cnt <= 0; err_cnt <= 0;
      end else begin
         if (req && !ack) begin
            ack   <= 1'b1;
            rdata <= rd_word(addr);
            berr  <= err_arm && (addr == err_addr);
         end else begin
            ack  <= 1'b0;
            berr <= 1'b0;
         end
         if (req && ack && we && !berr) begin
            wl_addr[wcount % 64] <= addr;
            wl_data[wcount % 64] <= wdata;
            wl_sz[wcount % 64]   <= msz;
            wcount <= wcount + 1;
         end
         if (done) done_cnt <= done_cnt + 1;
         if (errp) err_cnt <= err_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [1:0] m, input logic d, input logic [31:0] dv,
                         input logic [31:0] mm, input logic [31:0] sz, input logic [31:0] nx);
      @(negedge clk);
      mode = m; dir = d; dev_a = dv; mem_a = mm; size_w = sz; next_w = nx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (state != 2'd0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk({tag, " reaches idle"}, {30'd0, state}, 32'd0);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_single(input logic [1:0] code, input logic d, input int cnt, input logic [1:0] nx);
      int b0, d0;
      int bytes;
      logic [31:0] dv, mm, src, dst;
      bytes = (code == 2'd3) ? 1 : (code == 2'd2) ? 2 : 4;
      dv = 32'h9000_0000 + {24'd0, code, 6'd0};
      mm = 32'h0001_0000 + (cnt << 8) + {31'd0, d} * 32'h40;
      b0 = wcount; d0 = done_cnt;
      launch(2'd2, d, dv, mm, {18'd0, code, 1'b0, 11'(cnt)}, {30'd0, nx});
      wait_idle("R5 single");
      chk("R2 element count written", wcount - b0, cnt);
      chk("R9 done follows next bit 0", done_cnt - d0, {31'd0, nx[0]});
      for (int k = 0; k < cnt; k++) begin
         src = d ? mm + k * bytes : dv;
         dst = d ? dv : mm + k * bytes;
         chk("R8 write address", wl_addr[(b0 + k) % 64], dst);
         chk("R12 write data from read", wl_data[(b0 + k) % 64], src ^ 32'hC300_0000);
         chk("R2 access size", {30'd0, wl_sz[(b0 + k) % 64]}, (bytes == 1) ? 0 : (bytes == 2) ? 1 : 2);
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int b0, d0, e0;
      int sizes [3];
      logic [1:0] codes [3];
      sizes = '{1, 2, 7};
      codes = '{2'd3, 2'd2, 2'd0};
      for (int i = 0; i < 64; i++) dmem[i] = '0;
      repeat (3) @(negedge clk);
      chk("R6 reset state", {30'd0, state}, 0);
      chk("R12 reset no request", {31'd0, req}, 0);
      chk("R9 reset done low", {31'd0, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 state progression in single mode
      launch(2'd2, 1'b1, 32'h9900_0000, 32'h0000_2000, 32'h0000_0002, 32'd0);
      chk("R6 check state after start", {30'd0, state}, 2);
      @(negedge clk);
      chk("R6 access state", {30'd0, state}, 3);
      wait_idle("R6 single");

      // sweep: widths x directions x counts
      for (int ci = 0; ci < 3; ci++)
         for (int d = 0; d < 2; d++)
            for (int si = 0; si < 3; si++)
               run_single(codes[ci], d[0], sizes[si], (si == 0) ? 2'd1 : (si == 1) ? 2'd3 : 2'd0);

      // R1 R4 chain of three descriptors
      dmem[0]  = 32'h9100_0000; dmem[1]  = 32'h0000_5000; dmem[2]  = 32'h0000_0002; dmem[3]  = 32'h0000_0423;
      dmem[8]  = 32'h9100_0000; dmem[9]  = 32'h0000_6000; dmem[10] = 32'h0000_3003; dmem[11] = 32'h0000_0442;
      dmem[16] = 32'h9100_0000; dmem[17] = 32'h0000_7000; dmem[18] = 32'h0000_2001; dmem[19] = 32'h0000_0001;
      b0 = wcount; d0 = done_cnt;
      launch(2'd1, 1'b1, 32'h1111_1111, 32'h2222_2222, 32'h0000_0005, 32'h0000_0402);
      chk("R6 descriptor read state", {30'd0, state}, 1);
      wait_idle("R1 chain");
      chk("R4 chain total writes", wcount - b0, 6);
      chk("R9 chain done pulses", done_cnt - d0, 2);
      begin
         logic [31:0] srcs [6];
         srcs = '{32'h5000, 32'h5004, 32'h6000, 32'h6001, 32'h6002, 32'h7000};
         for (int k = 0; k < 6; k++) begin
            chk("R1 chain write to fetched device", wl_addr[(b0 + k) % 64], 32'h9100_0000);
            chk("R1 chain data from fetched memory", wl_data[(b0 + k) % 64], srcs[k] ^ 32'hC300_0000);
         end
      end

      // R3 largest legal narrow count
      b0 = wcount; e0 = err_cnt;
      launch(2'd2, 1'b1, 32'h9300_0000, 32'h0002_0000, 32'h0000_33FF, 32'd0);
      wait_idle("R3 max count");
      chk("R3 max narrow count moves all", wcount - b0, 32'h3FF);
      chk("R3 last address", wl_addr[(b0 + 1022) % 64], 32'h9300_0000);
      chk("R3 last data", wl_data[(b0 + 1022) % 64], (32'h0002_0000 + 1022) ^ 32'hC300_0000);
      chk("R3 no error at max", err_cnt - e0, 0);

      // R3 first illegal count
      b0 = wcount; e0 = err_cnt;
      launch(2'd2, 1'b1, 32'h9300_0000, 32'h0002_0000, 32'h0000_3400, 32'd1);
      wait_idle("R3 over max");
      chk("R3 over max error", err_cnt - e0, 1);
      chk("R3 over max no writes", wcount - b0, 0);

      // R10 width code 1
      b0 = wcount; e0 = err_cnt; d0 = done_cnt;
      launch(2'd2, 1'b0, 32'h9300_0000, 32'h0002_0000, 32'h0000_1002, 32'd1);
      wait_idle("R10 bad width");
      chk("R10 bad width error", err_cnt - e0, 1);
      chk("R10 bad width no writes", wcount - b0, 0);
      chk("R10 bad width no done", done_cnt - d0, 0);

      // R10 bus error on a data read
      err_addr = 32'h0000_A008; err_arm = 1'b1;
      b0 = wcount; e0 = err_cnt; d0 = done_cnt;
      launch(2'd2, 1'b1, 32'h9400_0000, 32'h0000_A000, 32'h0000_0004, 32'd1);
      wait_idle("R10 data bus error");
      chk("R10 writes before bus error", wcount - b0, 2);
      chk("R10 bus error pulse", err_cnt - e0, 1);
      chk("R10 no done after bus error", done_cnt - d0, 0);

      // R10 bus error on a descriptor read
      err_addr = 32'h0000_0488;
      b0 = wcount; e0 = err_cnt;
      launch(2'd1, 1'b1, 32'd0, 32'd0, 32'd0, 32'h0000_0480);
      wait_idle("R10 fetch bus error");
      chk("R10 fetch error pulse", err_cnt - e0, 1);
      chk("R10 fetch error no writes", wcount - b0, 0);
      err_arm = 1'b0;

      // R2 R9 zero count
      b0 = wcount; d0 = done_cnt;
      launch(2'd2, 1'b1, 32'h9500_0000, 32'h0000_C000, 32'h0000_0000, 32'd1);
      wait_idle("R2 zero count");
      chk("R2 zero count no writes", wcount - b0, 0);
      chk("R9 zero count done", done_cnt - d0, 1);

      // R11 abort part way
      b0 = wcount; d0 = done_cnt;
      launch(2'd2, 1'b1, 32'h9600_0000, 32'h0000_D000, 32'h0000_0032, 32'd1);
      repeat (20) @(negedge clk);
      mode = 2'd0;
      @(negedge clk);
      chk("R11 idle after disable", {30'd0, state}, 0);
      e0 = wcount;
      repeat (10) @(negedge clk);
      chk("R11 no writes after abort", wcount - e0, 0);
      chk("R11 abort stopped early", {31'd0, (wcount - b0) < 50}, 1);
      chk("R11 no done on abort", done_cnt - d0, 0);

      // R11 start while disabled does nothing
      launch(2'd0, 1'b1, 32'h9600_0000, 32'h0000_D000, 32'h0000_0004, 32'd1);
      chk("R11 disabled start stays idle", {30'd0, state}, 0);
      e0 = wcount;
      repeat (10) @(negedge clk);
      chk("R11 disabled start no writes", wcount - e0, 0);

      // R7 start while busy is ignored
      b0 = wcount; d0 = done_cnt;
      launch(2'd2, 1'b1, 32'h9700_0000, 32'h0000_E000, 32'h0000_000A, 32'd1);
      repeat (6) @(negedge clk);
      launch(2'd2, 1'b0, 32'h9800_0000, 32'h0000_F000, 32'h0000_3002, 32'd0);
      wait_idle("R7 busy start");
      chk("R7 original count kept", wcount - b0, 10);
      chk("R7 original done kept", done_cnt - d0, 1);
      chk("R7 last write original device", wl_addr[(b0 + 9) % 64], 32'h9700_0000);
      chk("R7 last data original memory", wl_data[(b0 + 9) % 64], (32'h0000_E000 + 36) ^ 32'hC300_0000);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule